// File: doc/BRIEF.md
# Binary XNOR-Popcount Convolution Lane Array

This block is the arithmetic core of a binarised convolution engine. Every accepted beat carries one packed activation vector, which all lanes share, and one packed weight vector for each lane. Each lane XNORs the two vectors and counts the ones with per-byte lookup tables and an adder. It turns the count into a signed ±1 dot product and adds that product into a running window sum.

When a beat is flagged as the last one of a kernel window, every lane applies a folded normalisation step to its window sum. The step is one signed 8-bit multiply, an arithmetic right shift and a signed 8-bit bias add, and the result is saturated to a signed byte. The lanes emit their results together as one output beat. Both ends use a valid/ready handshake. A single stall signal freezes every pipeline stage at once, so no partial result is lost or duplicated.

Top module: `bnn_xnor_pe`

## Requirements
- R1: A bit value of 1 stands for +1 and 0 stands for -1. The per-beat contribution of a lane is the sum of the element-wise products, which equals 2*P - N, where P is the number of ones in XNOR(activation, weight) and N = 8*VEC_SIZE.
- R2: Lane l uses weight bits in_wgt[l*N +: N] and the shared in_act. Its result sits in out_res[l*8 +: 8].
- R3: The ones count of the XNOR vector is formed from one 256-entry lookup per byte, and the byte counts are then summed. The total equals the true population count.
- R4: A window begins with the first accepted beat after reset or after a beat with in_last=1, and it ends with the accepted beat that has in_last=1. Each window produces exactly one output beat, and output beats leave in window order.
- R5: Each lane result is sat8(((S * scale) >>> shift) + bias). S is the window sum, scale and bias are two's-complement bytes (lane l at bits [l*8 +: 8]), shift is unsigned, and >>> is an arithmetic shift that rounds toward minus infinity.
- R6: Results above 127 are output as 127, and results below -128 are output as -128.
- R7: The scale, bias and shift values applied to a window are those presented with its last beat. Values presented with earlier beats have no effect.
- R8: With out_ready held high, out_valid rises on the second rising edge after the edge that accepts the last beat of a window.
- R9: in_ready equals (not out_valid) or out_ready. While out_valid=1 and out_ready=0, out_valid and out_res stay unchanged.
- R10: During and right after reset, out_valid=0, in_ready=1 and out_res=0. The first window after reset starts from a zero sum.
- R11: With out_ready high, a new beat is accepted on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_last | input | 1 | Beat closes the current window |
| in_act | input | 8*VEC_SIZE | Packed activation bits shared by all lanes |
| in_wgt | input | LANE_NUM*8*VEC_SIZE | Packed weight bits, one slice per lane |
| in_scale | input | LANE_NUM*8 | Signed scale byte per lane, used on the last beat |
| in_bias | input | LANE_NUM*8 | Signed bias byte per lane, used on the last beat |
| in_shift | input | SHIFT_W | Right-shift amount, used on the last beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_res | output | LANE_NUM*8 | Signed saturated result per lane |

## Verification
Some properties are checked on every cycle:
- The table-based count always equals the true population count.
- A lane's running sum never leaves ±N times the number of beats accumulated so far.
- in_ready is high whenever the output stage is empty.
- A stalled output holds still.
- An output beat is staged only after a flagged last beat has moved forward.

Other behaviour can only be shown by the bench's scenarios. These are the dot-product values themselves, the rounding and saturation of the normalisation step, the rule that only the last beat's parameters count, the two-cycle latency, and the absence of lost or extra windows under random backpressure.

// File: rtl/bnn_pe_pkg.sv
package bnn_pe_pkg;

  // Packed 256 x 4-bit table: entry k holds the number of ones in byte k.
  function automatic logic [1023:0] build_pop_lut();
    logic [1023:0] t;
    t = '0;
    for (int k = 0; k < 256; k++) begin
      logic [3:0] c;
      c = '0;
      for (int b = 0; b < 8; b++) c = c + 4'(k[b]);
      t[k*4 +: 4] = c;
    end
    return t;
  endfunction

  // Folded normalisation: multiply, arithmetic shift, bias add, byte saturation.
  function automatic logic signed [7:0] bn_finish(input longint sum,
                                                  input logic signed [7:0] scale,
                                                  input logic signed [7:0] bias,
                                                  input int unsigned shamt);
    longint p;
    p = sum * longint'(scale);
    p = p >>> shamt;
    p = p + longint'(bias);
    if (p > 127) return 8'sd127;
    if (p < -128) return -8'sd128;
    return p[7:0];
  endfunction

endpackage

// File: rtl/bnn_xnor_pop.sv
module bnn_xnor_pop #(
  parameter int VEC_SIZE = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [8*VEC_SIZE-1:0]           act,
  input  logic [8*VEC_SIZE-1:0]           wgt,
  output logic [$clog2(8*VEC_SIZE+1)-1:0] pop
);
  localparam int N     = 8 * VEC_SIZE;
  localparam int POP_W = $clog2(N + 1);
  localparam logic [1023:0] POP_LUT = bnn_pe_pkg::build_pop_lut();

  logic [N-1:0] agree;
  logic [3:0]   byte_cnt [VEC_SIZE];

  assign agree = ~(act ^ wgt);

  for (genvar b = 0; b < VEC_SIZE; b++) begin : g_byte
    assign byte_cnt[b] = POP_LUT[{agree[b*8 +: 8], 2'b00} +: 4];
  end

  always_comb begin
    pop = '0;
    for (int b = 0; b < VEC_SIZE; b++) pop = pop + POP_W'(byte_cnt[b]);
  end

  // R3: table lookups and sum agree with a direct population count
  a_r3_lut_count: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop) == $countones(agree));

endmodule

// File: rtl/bnn_lane_acc.sv
module bnn_lane_acc #(
  parameter int N       = 64,
  parameter int POP_W   = 7,
  parameter int ACC_W   = 14,
  parameter int CNT_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    beat_valid,
  input  logic                    beat_last,
  input  logic [POP_W-1:0]        pop,
  output logic signed [ACC_W-1:0] sum
);
  logic signed [ACC_W-1:0] pop_ext;
  logic signed [ACC_W-1:0] partial;
  logic signed [ACC_W-1:0] acc_q;
  logic                    first_q;
  logic [CNT_W-1:0]        beats_q;

  assign pop_ext = $signed(ACC_W'(pop));
  assign partial = (pop_ext <<< 1) - $signed(ACC_W'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      first_q <= 1'b1;
      beats_q <= '0;
    end else if (adv && beat_valid) begin
      acc_q   <= (first_q ? '0 : acc_q) + partial;
      first_q <= beat_last;
      beats_q <= first_q ? CNT_W'(1) : beats_q + CNT_W'(1);
    end
  end

  assign sum = acc_q;

  // R1: the running sum stays within +-N per accumulated beat
  a_r1_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_q) <= N * int'(beats_q)) && (int'(acc_q) >= -N * int'(beats_q)));

endmodule

// File: rtl/bnn_bn_post.sv
module bnn_bn_post #(
  parameter int ACC_W   = 14,
  parameter int SHIFT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] sum,
  input  logic [7:0]              scale,
  input  logic [7:0]              bias,
  input  logic [SHIFT_W-1:0]      shamt,
  output logic [7:0]              res
);
  logic signed [7:0] res_d;

  always_comb
    res_d = bnn_pe_pkg::bn_finish(longint'(sum), $signed(scale), $signed(bias),
                                  32'(shamt));

  always_ff @(posedge clk) begin
    if (!rst_n)    res <= '0;
    else if (load) res <= res_d;
  end

endmodule

// File: rtl/bnn_xnor_pe.sv
module bnn_xnor_pe #(
  parameter int VEC_SIZE = 8,
  parameter int LANE_NUM = 4,
  parameter int MAX_WIN  = 64,
  parameter int SHIFT_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic                           in_last,
  input  logic [8*VEC_SIZE-1:0]          in_act,
  input  logic [LANE_NUM*8*VEC_SIZE-1:0] in_wgt,
  input  logic [LANE_NUM*8-1:0]          in_scale,
  input  logic [LANE_NUM*8-1:0]          in_bias,
  input  logic [SHIFT_W-1:0]             in_shift,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [LANE_NUM*8-1:0]          out_res
);
  localparam int N     = 8 * VEC_SIZE;
  localparam int POP_W = $clog2(N + 1);
  localparam int ACC_W = $clog2(N * MAX_WIN + 1) + 1;
  localparam int CNT_W = $clog2(MAX_WIN + 1);

  // Shared advance: every stage moves only when the output stage can drain.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 1: ones counts and beat side information
  logic                  s1_valid, s1_last;
  logic [LANE_NUM*8-1:0] s1_scale, s1_bias;
  logic [SHIFT_W-1:0]    s1_shift;
  // Stage 2: window sums and the parameters of the closing beat
  logic                  s2_valid;
  logic [LANE_NUM*8-1:0] s2_scale, s2_bias;
  logic [SHIFT_W-1:0]    s2_shift;
  logic                  close_window;

  assign close_window = adv && s1_valid && s1_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_last   <= 1'b0;
      s1_scale  <= '0;
      s1_bias   <= '0;
      s1_shift  <= '0;
      s2_valid  <= 1'b0;
      s2_scale  <= '0;
      s2_bias   <= '0;
      s2_shift  <= '0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      s2_valid  <= s1_valid && s1_last;
      out_valid <= s2_valid;
      if (in_valid) begin
        s1_last  <= in_last;
        s1_scale <= in_scale;
        s1_bias  <= in_bias;
        s1_shift <= in_shift;
      end
      if (close_window) begin
        s2_scale <= s1_scale;
        s2_bias  <= s1_bias;
        s2_shift <= s1_shift;
      end
    end
  end

  for (genvar l = 0; l < LANE_NUM; l++) begin : g_lane
    logic [POP_W-1:0]        pop_d, pop_q;
    logic signed [ACC_W-1:0] win_sum;

    bnn_xnor_pop #(.VEC_SIZE(VEC_SIZE)) u_pop (
      .clk (clk),
      .rst_n (rst_n),
      .act (in_act),
      .wgt (in_wgt[l*N +: N]),
      .pop (pop_d)
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                pop_q <= '0;
      else if (adv && in_valid)  pop_q <= pop_d;
    end

    bnn_lane_acc #(.N(N), .POP_W(POP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .beat_valid (s1_valid),
      .beat_last  (s1_last),
      .pop        (pop_q),
      .sum        (win_sum)
    );

    bnn_bn_post #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_post (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (adv && s2_valid),
      .sum   (win_sum),
      .scale (s2_scale[l*8 +: 8]),
      .bias  (s2_bias[l*8 +: 8]),
      .shamt (s2_shift),
      .res   (out_res[l*8 +: 8])
    );
  end

  // R9: an empty output stage never refuses input
  a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9: a stalled result is held unchanged
  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  // R4: a window result is staged only after a flagged last beat moved on
  a_r4_result_per_window: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && $past(adv)) |-> $past(s1_valid && s1_last));

endmodule

// File: tb/bnn_xnor_pe_bench.sv
`timescale 1ns/1ps
module bnn_xnor_pe_bench;
  localparam int VEC_SIZE = 8;
  localparam int LANE_NUM = 4;
  localparam int MAX_WIN  = 64;
  localparam int SHIFT_W  = 4;
  localparam int N        = 8 * VEC_SIZE;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0, in_last = 1'b0;
  logic                  in_ready;
  logic [N-1:0]          in_act = '0;
  logic [LANE_NUM*N-1:0] in_wgt = '0;
  logic [LANE_NUM*8-1:0] in_scale = '0, in_bias = '0;
  logic [SHIFT_W-1:0]    in_shift = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b1;
  logic [LANE_NUM*8-1:0] out_res;

  bnn_xnor_pe #(.VEC_SIZE(VEC_SIZE), .LANE_NUM(LANE_NUM), .MAX_WIN(MAX_WIN),
                .SHIFT_W(SHIFT_W)) u_bnn_xnor_pe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt), .in_scale(in_scale),
    .in_bias(in_bias), .in_shift(in_shift), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res));

  int checks = 0, fails = 0;
  bit rand_ready = 1'b0, monitor_on = 1'b0;
  string cur_tag = "R1 R2 R3 R5";
  int run_sum [LANE_NUM];
  logic [LANE_NUM*8-1:0] exp_q [$];

  initial forever #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Behavioural +-1 dot product (R1)
  function automatic int dot_pm1(input logic [N-1:0] a, input logic [N-1:0] w);
    int d = 0;
    for (int i = 0; i < N; i++) d += (a[i] == w[i]) ? 1 : -1;
    return d;
  endfunction

  // Normalisation reference (R5, R6)
  function automatic logic [7:0] ref_norm(input int s, input logic [7:0] sc,
                                          input logic [7:0] bi, input int sh);
    longint p;
    p = longint'(s) * longint'($signed(sc));
    p = p >>> sh;
    p = p + longint'($signed(bi));
    if (p > 127) p = 127;
    if (p < -128) p = -128;
    return 8'(p);
  endfunction

  function automatic logic [N-1:0] rand_bits();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  // out_ready driven just after each rising edge
  initial forever begin
    @(posedge clk); #3;
    out_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // Output monitor: pairs every output beat with the oldest expected window (R4, R9)
  initial begin
    bit held = 1'b0;
    logic [LANE_NUM*8-1:0] held_val = '0;
    forever begin
      @(negedge clk);
      if (monitor_on) begin
        if (held) begin
          check(out_valid === 1'b1, "R9 stall keeps out_valid", out_valid, 1);
          check(out_res === held_val, "R9 stall keeps out_res", out_res, held_val);
        end
        held = out_valid && !out_ready;
        held_val = out_res;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected output beat", 1, 0);
          end else begin
            logic [LANE_NUM*8-1:0] e;
            e = exp_q.pop_front();
            for (int l = 0; l < LANE_NUM; l++)
              check(out_res[l*8 +: 8] === e[l*8 +: 8], {cur_tag, " lane result"},
                    $signed(out_res[l*8 +: 8]), $signed(e[l*8 +: 8]));
          end
        end
      end
    end
  end

  // Drives one beat from just after an edge, holds it until accepted, updates the model.
  task automatic send_beat(input logic [N-1:0] a, input logic [LANE_NUM*N-1:0] w,
                           input bit last, input logic [LANE_NUM*8-1:0] sc,
                           input logic [LANE_NUM*8-1:0] bi, input logic [SHIFT_W-1:0] sh,
                           output int waits);
    in_valid = 1'b1; in_act = a; in_wgt = w; in_last = last;
    in_scale = sc; in_bias = bi; in_shift = sh;
    waits = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waits++;
      @(posedge clk); #3;
    end
    for (int l = 0; l < LANE_NUM; l++) run_sum[l] += dot_pm1(a, w[l*N +: N]);
    if (last) begin
      logic [LANE_NUM*8-1:0] e;
      for (int l = 0; l < LANE_NUM; l++) begin
        e[l*8 +: 8] = ref_norm(run_sum[l], sc[l*8 +: 8], bi[l*8 +: 8], int'(sh));
        run_sum[l] = 0;
      end
      exp_q.push_back(e);
    end
    @(posedge clk); #3;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // mode 0: random bits, 1: weights equal activation, 2: weights inverted
  // fixed=0 randomises scale/bias/shift on every beat (R7)
  task automatic send_window(input int len, input int mode, input bit fixed,
                             input logic [LANE_NUM*8-1:0] sc, input logic [LANE_NUM*8-1:0] bi,
                             input logic [SHIFT_W-1:0] sh, output int total_waits);
    int w8;
    total_waits = 0;
    for (int k = 0; k < len; k++) begin
      logic [N-1:0] a;
      logic [LANE_NUM*N-1:0] w;
      logic [LANE_NUM*8-1:0] bsc, bbi;
      logic [SHIFT_W-1:0] bsh;
      a = rand_bits();
      for (int l = 0; l < LANE_NUM; l++)
        w[l*N +: N] = (mode == 1) ? a : (mode == 2) ? ~a : rand_bits();
      bsc = fixed ? sc : {$urandom, $urandom};
      bbi = fixed ? bi : {$urandom, $urandom};
      bsh = fixed ? sh : SHIFT_W'($urandom % 8);
      send_beat(a, w, k == len - 1, bsc, bbi, bsh, w8);
      total_waits += w8;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    int waits;
    for (int l = 0; l < LANE_NUM; l++) run_sum[l] = 0;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid in reset", out_valid, 0);
    @(posedge clk); #3; rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R10 in_ready after reset", in_ready, 1);
    check(out_valid === 1'b0, "R10 out_valid after reset", out_valid, 0);
    check(out_res === '0, "R10 out_res after reset", out_res, 0);
    monitor_on = 1'b1;
    @(posedge clk); #3;

    // R11: back-to-back beats with out_ready high, all-agree sum 4*64=256
    cur_tag = "R1 R11";
    send_window(4, 1, 1'b1, {8'd1, 8'd2, 8'd3, 8'd4}, {8'd0, 8'hF6, 8'd5, 8'd0}, 4'd4, waits);
    check(waits == 0, "R11 every beat accepted at once", waits, 0);
    idle(6);

    // R8: single-beat window latency
    cur_tag = "R8 R1";
    send_window(1, 0, 1'b1, {4{8'd1}}, '0, '0, waits);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 not valid after 1 edge", out_valid, 0);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 not valid after 2 edges", out_valid, 0);
    @(negedge clk);
    check(out_valid === 1'b1, "R8 valid after 3rd edge", out_valid, 1);
    idle(4);

    // R6: saturation both ways (sum +4096 and -4096), mixed sign scales
    cur_tag = "R6";
    send_window(MAX_WIN, 1, 1'b1, {8'd127, 8'h80, 8'd1, 8'd0}, {8'd127, 8'd0, 8'd0, 8'h80}, 4'd0, waits);
    send_window(MAX_WIN, 2, 1'b1, {8'd127, 8'h80, 8'd1, 8'd1}, {8'd0, 8'd0, 8'd0, 8'h80}, 4'd5, waits);

    // R5: shift rounds toward minus infinity; weights with 33 ones against zero activation give sum -2
    cur_tag = "R5";
    begin
      logic [LANE_NUM*N-1:0] w;
      for (int l = 0; l < LANE_NUM; l++) w[l*N +: N] = {{(N-33){1'b0}}, {33{1'b1}}};
      send_beat('0, w, 1'b1, {8'd1, 8'd1, 8'd3, 8'd1}, {8'd0, 8'd0, 8'd0, 8'd7}, 4'd2, waits);
    end
    idle(4);

    // R7: parameters differ on every beat; only the last beat's values count
    cur_tag = "R7 R2";
    for (int t = 0; t < 4; t++) send_window(2 + t, 0, 1'b0, '0, '0, '0, waits);

    // R1 R2 R3 R4 R9: random windows under random backpressure
    cur_tag = "R1 R2 R3 R4 R9";
    rand_ready = 1'b1;
    for (int t = 0; t < 40; t++)
      send_window(1 + int'($urandom % MAX_WIN), 0, 1'b0, '0, '0, '0, waits);
    rand_ready = 1'b0;

    // R4: all windows drained, none lost
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(posedge clk);
    idle(4);
    check(exp_q.size() == 0, "R4 every window produced a result", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule